// File: doc/BRIEF.md
# Status Change Notification and Interrupt Register

This block gathers a vector of live condition flags into one place where software can read them. Examples are configuration-load-complete, checksum error, loss of an input clock, loss of lock in a PLL and holdover entry in a PLL. Each flag comes from another clock domain or from a slow monitor. It is resynchronised, and its current value can be read as a status bit.

Any change of a flag, whether rising or falling, latches a sticky notify bit. Each notify bit is gated by a mask bit. The gated bits are ORed onto a single active-low interrupt line. Software reads the notify bits to find the cause and then clears them by writing ones.

The register port is a simple one-cycle write strobe with combinational read data. The address selects the register kind and the byte. Flags are packed eight to a byte. For per-PLL groups, bit 0 of a byte is the first PLL, bit 1 the second, and so on.

Top module: `stat_notify_irq`

## Requirements
- R1: The status register reads the value of `statusIn` as it was before the second rising clock edge. The two-flop resynchroniser gives a latency of exactly two edges.
- R2: A change of a status bit in either direction sets its notify bit. The notify bit reads 1 after the third rising edge following the input change, and still reads 0 after the second.
- R3: A set notify bit stays set while no clear is written, even after its status bit returns to the previous level.
- R4: Writing to a notify byte clears each notify bit whose data bit is 1. Bits written as 0 are left unchanged.
- R5: If a status toggle reaches a notify bit in the same cycle as a clear of that bit, the bit ends set.
- R6: After reset every mask bit is 1. A write to a mask byte replaces that byte, and the mask reads back what was written.
- R7: `irqN` is 0 exactly when at least one notify bit and its mask bit are both 1. A mask bit of 0 removes only the interrupt contribution; the notify bit still latches and reads back.
- R8: The address is {kind[1:0], byte index}. Kind 0 is status (read-only, writes ignored), kind 1 is notify, kind 2 is mask, and kind 3 reads 0.
- R9: After reset the status and notify registers read 0 and `irqN` is 1.
- R10: Bit i of byte j in each register kind corresponds to `statusIn[8*j+i]`.

Top module port order follows the table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| statusIn | input | STATUS_W (16) | Raw condition flags |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regAddr | input | ADDR_W (3) | {kind, byte index} |
| regWrData | input | REG_W (8) | Write data |
| regRdData | output | REG_W (8) | Combinational read data for `regAddr` |
| irqN | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `statusIn` is held at 0 while reset is asserted, so the resynchroniser and its edge reference start out equal. They also assume that a write lasts exactly one cycle. The bench changes `statusIn` only after reset is released, and holds each new value for at least three edges so that every change is seen as exactly one toggle. Every write strobe it issues is released one time unit after the edge that takes it.

// File: rtl/snm_pkg.sv
package snm_pkg;
  typedef enum logic [1:0] {
    SEL_STAT   = 2'd0,
    SEL_NOTIFY = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrNotify;
    logic    wrMask;
    regSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/snm_ctrl.sv
module snm_ctrl
  import snm_pkg::*;
#(
  parameter int IDX_W  = 1,
  parameter int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe,
  output logic [IDX_W-1:0]  idx
);
  regSel_e sel;

  assign sel = regSel_e'(regAddr[ADDR_W-1 -: 2]);
  assign idx = regAddr[IDX_W-1:0];

  always_comb begin
    strobe.rdSel    = sel;
    strobe.wrNotify = regWrEn && (sel == SEL_NOTIFY);
    strobe.wrMask   = regWrEn && (sel == SEL_MASK);
  end

  // R8
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr[ADDR_W-1 -: 2] == 2'd0) |-> !(strobe.wrNotify || strobe.wrMask));
endmodule

// File: rtl/snm_datapath.sv
module snm_datapath
  import snm_pkg::*;
#(
  parameter int STATUS_W = 16,
  parameter int REG_W    = 8,
  parameter int NUM_REGS = STATUS_W / REG_W,
  parameter int IDX_W    = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] statusIn,
  input  regStrobe_t          strobe,
  input  logic [IDX_W-1:0]    idx,
  input  logic [REG_W-1:0]    wrData,
  output logic [REG_W-1:0]    rdData,
  output logic                irqN
);
  logic [STATUS_W-1:0] sync1, syncStat, prevStat;
  logic [STATUS_W-1:0] notify, mask, clrVec, tog;
  logic [NUM_REGS-1:0] maskHit;

  // two-flop resynchroniser plus edge reference
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1    <= '0;
      syncStat <= '0;
      prevStat <= '0;
    end else begin
      sync1    <= statusIn;
      syncStat <= sync1;
      prevStat <= syncStat;
    end
  end

  assign tog = syncStat ^ prevStat;

  // per-byte write decode and mask storage
  for (genvar g = 0; g < NUM_REGS; g++) begin : gByte
    logic hit;
    assign hit = (idx == IDX_W'(g));
    assign clrVec[g*REG_W +: REG_W] = (strobe.wrNotify && hit) ? wrData : '0;
    assign maskHit[g] = strobe.wrMask && hit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           mask[g*REG_W +: REG_W] <= '1;
      else if (maskHit[g]) mask[g*REG_W +: REG_W] <= wrData;
    end
  end

  // sticky notify: a set from a toggle wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) notify <= '0;
    else       notify <= (notify & ~clrVec) | tog;
  end

  assign irqN = ~|(notify & mask);

  always_comb begin
    rdData = '0;
    if (32'(idx) < NUM_REGS) begin
      case (strobe.rdSel)
        SEL_STAT:   rdData = syncStat[idx*REG_W +: REG_W];
        SEL_NOTIFY: rdData = notify[idx*REG_W +: REG_W];
        SEL_MASK:   rdData = mask[idx*REG_W +: REG_W];
        default:    rdData = '0;
      endcase
    end
  end

  // R3
  notify_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(notify) & ~$past(clrVec) & ~notify) == '0));

  // R2
  toggle_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(tog) & ~notify) == '0));

  // R2
  notify_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((notify & ~$past(notify) & ~$past(tog)) == '0));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.wrMask) |-> $stable(mask));

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (|notify));
endmodule

// File: rtl/stat_notify_irq.sv
module stat_notify_irq
  import snm_pkg::*;
#(
  parameter int STATUS_W = 16,
  parameter int REG_W    = 8,
  localparam int NUM_REGS = STATUS_W / REG_W,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ADDR_W   = IDX_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] statusIn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic                irqN
);
  regStrobe_t       strobe;
  logic [IDX_W-1:0] idx;

  snm_ctrl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .strobe(strobe), .idx(idx)
  );

  snm_datapath #(.STATUS_W(STATUS_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .statusIn(statusIn), .strobe(strobe), .idx(idx),
    .wrData(regWrData), .rdData(regRdData), .irqN(irqN)
  );
endmodule

// File: tb/stat_notify_irq_tb.sv
module stat_notify_irq_tb_top;
  localparam int SW = 16;

  logic        clk = 0;
  logic        rstN = 0;
  logic [SW-1:0] statusIn = '0;
  logic        regWrEn = 0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        irqN;

  int nTests = 0, nFail = 0;
  bit done = 0;
  logic [SW-1:0] expStat = '0, expNotify = '0, expMask = '1;

  always #4 clk = ~clk;

  stat_notify_irq dut_i (
    .clk(clk), .rstN(rstN), .statusIn(statusIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irqN(irqN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd16(input logic [1:0] sel, output logic [15:0] v);
    regAddr = {sel, 1'b0}; #1; v[7:0]  = regRdData;
    regAddr = {sel, 1'b1}; #1; v[15:8] = regRdData;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] sel, input logic idx, input logic [7:0] d);
    regAddr = {sel, idx}; regWrData = d; regWrEn = 1;
    @(posedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic expIrq(input string tag);
    chk(tag, {31'd0, irqN}, {31'd0, ~|(expNotify & expMask)});
  endtask

  task automatic checkAll(input string tag);
    logic [15:0] v;
    rd16(2'd0, v); chk({tag, " status"}, v, expStat);
    rd16(2'd1, v); chk({tag, " notify"}, v, expNotify);
    rd16(2'd2, v); chk({tag, " mask"}, v, expMask);
    expIrq({tag, " irq"});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    edges(3);
    rstN = 1;
    edges(1);
    // R9 R6: reset state
    checkAll("R9 reset");
    // R8: kind 3 reads zero
    regAddr = 3'b110; #1; chk("R8 kind3 byte0", regRdData, 8'h00);
    regAddr = 3'b111; #1; chk("R8 kind3 byte1", regRdData, 8'h00);

    // per-bit sweep, both edges
    for (int b = 0; b < SW; b++) begin
      statusIn[b] = 1'b1; expStat[b] = 1'b1;
      edges(2);
      rd16(2'd0, v); chk("R1 status after 2 edges", v, expStat);
      rd16(2'd1, v); chk("R2 notify not yet", v, 16'h0);
      edges(1);
      expNotify = 16'(1) << b;
      rd16(2'd1, v); chk("R2 R10 rise sets bit", v, expNotify);
      expIrq("R7 irq low");
      statusIn[b] = 1'b0; expStat[b] = 1'b0;
      edges(3);
      rd16(2'd1, v); chk("R3 sticky after return", v, expNotify);
      wr(2'd1, 1'(b / 8), 8'h00);
      rd16(2'd1, v); chk("R4 zero write keeps", v, expNotify);
      wr(2'd1, 1'(b / 8), 8'(1 << (b % 8)));
      expNotify = '0;
      rd16(2'd1, v); chk("R4 w1c clears", v, 16'h0);
      expIrq("R7 irq released");
      // fall edge alone also sets
      statusIn[b] = 1'b1; expStat[b] = 1'b1; edges(3);
      wr(2'd1, 1'(b / 8), 8'hFF); expNotify = '0;
      statusIn[b] = 1'b0; expStat[b] = 1'b0; edges(3);
      expNotify = 16'(1) << b;
      rd16(2'd1, v); chk("R2 fall sets bit", v, expNotify);
      wr(2'd1, 1'(b / 8), 8'hFF); expNotify = '0;
    end
    checkAll("R9 after sweep");

    // R6 R7: masking
    wr(2'd2, 1'b0, 8'h00); expMask[7:0] = 8'h00;
    checkAll("R6 mask write");
    statusIn[3] = 1'b1; expStat[3] = 1'b1; edges(3); expNotify[3] = 1'b1;
    checkAll("R7 masked notify latches");
    chk("R7 masked irq high", {31'd0, irqN}, 32'd1);
    wr(2'd2, 1'b0, 8'h08); expMask[7:0] = 8'h08;
    chk("R7 unmask irq low", {31'd0, irqN}, 32'd0);

    // R8: write to status ignored
    wr(2'd0, 1'b0, 8'hFF);
    wr(2'd0, 1'b1, 8'hFF);
    checkAll("R8 status write ignored");
    wr(2'd3, 1'b0, 8'hFF);
    checkAll("R8 kind3 write ignored");

    // R5: toggle and clear meet in the same edge
    statusIn[3] = 1'b0; expStat[3] = 1'b0;
    edges(2);
    wr(2'd1, 1'b0, 8'h08);
    rd16(2'd1, v); chk("R5 set wins", v, expNotify);
    wr(2'd1, 1'b0, 8'h08); expNotify[3] = 1'b0;
    checkAll("R5 later clear");
    wr(2'd2, 1'b0, 8'hFF); expMask = '1;

    // R10: multi-bit pattern, byte-selective clear
    statusIn = 16'hA5C3; expStat = 16'hA5C3; edges(3); expNotify = 16'hA5C3;
    checkAll("R10 pattern");
    wr(2'd1, 1'b1, 8'hFF); expNotify = 16'h00C3;
    checkAll("R10 clear high byte");
    wr(2'd2, 1'b0, 8'h3C); expMask[7:0] = 8'h3C;
    checkAll("R7 mask misses notify");
    wr(2'd1, 1'b0, 8'h41); expNotify = 16'h0082;
    checkAll("R4 partial clear");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule